// File: doc/BRIEF.md
# Flash Reconfiguration Engine

This block sits between a host register bus and the controller of an on-chip configuration flash. The host sets an address and a data word through 32-bit registers. It then writes a command word whose one-shot bits start a read, a write or a sector erase on a generic flash port. The host polls a status word that has one idle flag for each operation. After a read completes, it collects the fetched word from a result register.

Writes and erases are guarded by a protection latch. Reset sets this latch, and the host sets or clears it with strobe bits in the command word. A write or erase that the latch refuses leaves a sticky error flag, which a read of the status word clears. Two read-only registers report the first and last word address of the reprogrammable region. A status bit mirrors a strap input. That strap tells the host software whether memory initialization is in use: if it is, sectors 2 through 4 must be cleared, and if not, only sector 4.

Top module: `flash_reconfig_engine`

## Requirements
- R1: After reset, the status word (offset 0x00) reads 0x0000_1111 with the strap low: protection on (bit 0), read idle (bit 4), erase idle (bit 8), write idle (bit 12). The result register (0x10) reads zero.
- R2: In a write to the command register (0x04), bit 0 sets protection and bit 1 clears it. If both bits are set, protection ends up set. With protection off and nothing running, status reads 0x0000_1110.
- R3: Command bit 2 starts a read of the flash word at the address register (0x08). Status bit 4 is low while the read runs. When the read completes, the fetched word appears at 0x10 and holds there until the next read completes.
- R4: Command bit 3 writes the data register (0x0C) to the flash word at the address register. Status bit 12 is low while the write runs.
- R5: Command bit 4 starts an erase of the sector given by command bits 7:5, and that number appears on `fl_sector`. Status bit 8 is low while the erase runs.
- R6: While protection is set, a write or erase command starts nothing and sets the error flag (status bit 20). A status read clears the flag. If a refused command and a status read fall in the same cycle, the read returns the old flag and the flag stays set.
- R7: Operation bits written while any operation is running are ignored and do not set the error flag.
- R8: If one command sets several operation bits, read wins over write, and write wins over erase. A refused write or erase does not raise the error flag when a read is started in the same command. The protection check uses the latch value from before the same command's protect bits.
- R9: Offsets 0x14 and 0x18 return the region start and end parameters, and writes to them are ignored.
- R10: Status bit 16 follows the `mem_init` input.
- R11: A read strobe returns data with `host_rd_valid` one cycle later. The command register and unmapped offsets read as zero.
- R12: The address and data registers read back the values last written to them.
- R13: A flash request line stays high until `fl_busy` is seen high. The operation then completes when `fl_busy` is seen low again. Each operation gives exactly one request handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_init | input | 1 | Memory-initialization strap, shown in status bit 16 |
| host_wr_en | input | 1 | Register write strobe |
| host_wr_addr | input | 5 | Register write byte offset |
| host_wr_data | input | 32 | Register write data |
| host_rd_en | input | 1 | Register read strobe |
| host_rd_addr | input | 5 | Register read byte offset |
| host_rd_data | output | 32 | Register read data, held until the next read |
| host_rd_valid | output | 1 | Read data valid, one cycle after the strobe |
| fl_addr | output | FADDR_W | Flash word address |
| fl_wdata | output | 32 | Flash write data |
| fl_sector | output | 3 | Sector number for erase |
| fl_read | output | 1 | Read request |
| fl_write | output | 1 | Write request |
| fl_erase | output | 1 | Erase request |
| fl_rdata | input | 32 | Flash read data, valid when busy falls after a read |
| fl_busy | input | 1 | Flash busy handshake |

## Verification
Two functions can fall in the same cycle. One is a protected write command setting the sticky error flag. The other is a status read, which clears that flag. The bench drives both strobes in the same cycle while protection is on. It expects that read to return the old status without bit 20. It expects the next status read to show the flag, and the read after that to show it cleared. A second case of the same kind is a command that carries a protect bit and a write bit together. Here the write must start, because it is judged against the earlier latch value, and status must show protection set with write busy.

// File: rtl/flash_reconfig_engine.sv
module flash_reconfig_engine #(
  parameter int          FADDR_W      = 16,
  parameter logic [31:0] REGION_START = 32'h0000_0100,
  parameter logic [31:0] REGION_END   = 32'h0000_01FF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mem_init,
  input  logic               host_wr_en,
  input  logic [4:0]         host_wr_addr,
  input  logic [31:0]        host_wr_data,
  input  logic               host_rd_en,
  input  logic [4:0]         host_rd_addr,
  output logic [31:0]        host_rd_data,
  output logic               host_rd_valid,
  output logic [FADDR_W-1:0] fl_addr,
  output logic [31:0]        fl_wdata,
  output logic [2:0]         fl_sector,
  output logic               fl_read,
  output logic               fl_write,
  output logic               fl_erase,
  input  logic [31:0]        fl_rdata,
  input  logic               fl_busy
);
  localparam logic [4:0] OFF_STAT  = 5'h00;
  localparam logic [4:0] OFF_CMD   = 5'h04;
  localparam logic [4:0] OFF_ADDR  = 5'h08;
  localparam logic [4:0] OFF_WDATA = 5'h0C;
  localparam logic [4:0] OFF_RDATA = 5'h10;
  localparam logic [4:0] OFF_START = 5'h14;
  localparam logic [4:0] OFF_END   = 5'h18;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;
  typedef enum logic [1:0] {OP_RD, OP_WR, OP_ER} op_t;

  state_t             state;
  op_t                op_q;
  logic               wp, err_q;
  logic [FADDR_W-1:0] addr_q;
  logic [31:0]        wdata_q, rword;
  logic [2:0]         sector_q;

  wire cmd_wr   = host_wr_en && host_wr_addr == OFF_CMD;
  wire want_rd  = host_wr_data[2];
  wire want_mod = host_wr_data[3] | host_wr_data[4];
  wire idle     = state == S_IDLE;
  wire start    = cmd_wr && idle && (want_rd || (!wp && want_mod));
  wire err_set  = cmd_wr && idle && wp && !want_rd && want_mod;
  wire stat_rd  = host_rd_en && host_rd_addr == OFF_STAT;
  op_t next_op;
  assign next_op = want_rd ? OP_RD : (host_wr_data[3] ? OP_WR : OP_ER);

  wire rd_idle = idle || op_q != OP_RD;
  wire wr_idle = idle || op_q != OP_WR;
  wire er_idle = idle || op_q != OP_ER;

  wire [31:0] status = {11'd0, err_q, 3'd0, mem_init, 3'd0, wr_idle,
                        3'd0, er_idle, 3'd0, rd_idle, 3'd0, wp};

  assign fl_read   = state == S_REQ && op_q == OP_RD;
  assign fl_write  = state == S_REQ && op_q == OP_WR;
  assign fl_erase  = state == S_REQ && op_q == OP_ER;
  assign fl_addr   = addr_q;
  assign fl_wdata  = wdata_q;
  assign fl_sector = sector_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= OP_RD;
      wp       <= 1'b1;
      err_q    <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rword    <= '0;
      sector_q <= '0;
    end else begin
      if (cmd_wr) begin
        if (host_wr_data[0])      wp <= 1'b1;
        else if (host_wr_data[1]) wp <= 1'b0;
      end
      if (err_set)      err_q <= 1'b1;
      else if (stat_rd) err_q <= 1'b0;
      if (host_wr_en && host_wr_addr == OFF_ADDR)  addr_q  <= host_wr_data[FADDR_W-1:0];
      if (host_wr_en && host_wr_addr == OFF_WDATA) wdata_q <= host_wr_data;
      case (state)
        S_IDLE: if (start) begin
          state <= S_REQ;
          op_q  <= next_op;
          if (next_op == OP_ER) sector_q <= host_wr_data[7:5];
        end
        S_REQ:  if (fl_busy) state <= S_WAIT;
        S_WAIT: if (!fl_busy) begin
          state <= S_IDLE;
          if (op_q == OP_RD) rword <= fl_rdata;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rd_data  <= '0;
      host_rd_valid <= 1'b0;
    end else begin
      host_rd_valid <= host_rd_en;
      if (host_rd_en) begin
        case (host_rd_addr)
          OFF_STAT:  host_rd_data <= status;
          OFF_ADDR:  host_rd_data <= 32'(addr_q);
          OFF_WDATA: host_rd_data <= wdata_q;
          OFF_RDATA: host_rd_data <= rword;
          OFF_START: host_rd_data <= REGION_START;
          OFF_END:   host_rd_data <= REGION_END;
          default:   host_rd_data <= '0;
        endcase
      end
    end
  end

  p_no_mod_protected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_write) || $rose(fl_erase)) |-> !$past(wp));
  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(wp));
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fl_read) || $rose(fl_write) || $rose(fl_erase)) |-> $past(state == S_IDLE));
  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ((fl_read || fl_write || fl_erase) && !fl_busy) |=> (fl_read || fl_write || fl_erase));
  p_idle_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_idle) |-> $past(host_wr_en));
  p_rword_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && $past(idle)) |-> $stable(rword));
endmodule

// File: tb/flash_reconfig_engine_tb.sv
`timescale 1ns/1ps
module flash_reconfig_engine_tb;
  localparam logic [31:0] RSTART = 32'h0000_0100;
  localparam logic [31:0] REND   = 32'h0000_01FF;

  logic clk = 0, rst_n = 0, mem_init = 0;
  logic host_wr_en = 0, host_rd_en = 0;
  logic [4:0] host_wr_addr = 0, host_rd_addr = 0;
  logic [31:0] host_wr_data = 0, host_rd_data;
  logic host_rd_valid;
  logic [15:0] fl_addr;
  logic [31:0] fl_wdata, fl_rdata;
  logic [2:0] fl_sector;
  logic fl_read, fl_write, fl_erase, fl_busy;

  always #2.5 clk = ~clk;

  flash_reconfig_engine #(.FADDR_W(16), .REGION_START(RSTART), .REGION_END(REND)) u_dut (
    .clk(clk), .rst_n(rst_n), .mem_init(mem_init),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .host_rd_en(host_rd_en), .host_rd_addr(host_rd_addr),
    .host_rd_data(host_rd_data), .host_rd_valid(host_rd_valid),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_sector(fl_sector),
    .fl_read(fl_read), .fl_write(fl_write), .fl_erase(fl_erase),
    .fl_rdata(fl_rdata), .fl_busy(fl_busy));

  logic [31:0] mem [16];
  logic [1:0] cnt;
  int wr_count, er_count, trig_count;
  logic [2:0] last_sector;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'hDEAD_0000 + 32'(i);
      fl_busy <= 0; fl_rdata <= 0; cnt <= 0;
      wr_count <= 0; er_count <= 0; trig_count <= 0; last_sector <= 0;
    end else if (!fl_busy && (fl_read || fl_write || fl_erase)) begin
      fl_busy <= 1; cnt <= 3; trig_count <= trig_count + 1;
      if (fl_read) fl_rdata <= mem[fl_addr[3:0]];
      if (fl_write) begin mem[fl_addr[3:0]] <= fl_wdata; wr_count <= wr_count + 1; end
      if (fl_erase) begin er_count <= er_count + 1; last_sector <= fl_sector; end
    end else if (fl_busy) begin
      if (cnt == 1) fl_busy <= 0;
      cnt <= cnt - 1;
    end
  end

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit chk_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && host_rd_valid) begin
      if (exp_q.size() == 0) check(0, "R11 unexpected valid", host_rd_data, 0);
      else begin
        logic [31:0] e; string t; bit c;
        e = exp_q.pop_front(); t = tag_q.pop_front(); c = chk_q.pop_front();
        if (c) check(host_rd_data == e, t, host_rd_data, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); host_wr_en = 1; host_wr_addr = a; host_wr_data = d;
    @(negedge clk); host_wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk); host_rd_en = 1; host_rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(t); chk_q.push_back(1);
    @(negedge clk); host_rd_en = 0;
  endtask

  task automatic wr_rd(input logic [4:0] wa, input logic [31:0] d, input logic [4:0] ra,
                       input logic [31:0] e, input string t);
    @(negedge clk); host_wr_en = 1; host_wr_addr = wa; host_wr_data = d;
    host_rd_en = 1; host_rd_addr = ra;
    exp_q.push_back(e); tag_q.push_back(t); chk_q.push_back(1);
    @(negedge clk); host_wr_en = 0; host_rd_en = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 40; k++) begin
      logic [31:0] v;
      @(negedge clk); host_rd_en = 1; host_rd_addr = 5'h00;
      exp_q.push_back(0); tag_q.push_back(""); chk_q.push_back(0);
      @(posedge clk); #1 v = host_rd_data;
      @(negedge clk); host_rd_en = 0;
      if ((v & 32'h1110) == 32'h1110) break;
    end
  endtask

  initial begin
    int t0, w0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(5'h00, 32'h0000_1111, "R1 reset status");
    rd(5'h10, 32'h0, "R1 reset result");
    rd(5'h14, RSTART, "R9 start");
    rd(5'h18, REND, "R9 end");
    wr(5'h14, 32'h1234_5678);
    wr(5'h18, 32'h1234_5678);
    rd(5'h14, RSTART, "R9 start after write");
    rd(5'h18, REND, "R9 end after write");
    wr(5'h08, 32'h5);
    wr(5'h0C, 32'hA5A5_1234);
    rd(5'h08, 32'h5, "R12 address");
    rd(5'h0C, 32'hA5A5_1234, "R12 data");
    mem_init = 1;
    rd(5'h00, 32'h0001_1111, "R10 strap high");
    mem_init = 0;
    rd(5'h00, 32'h0000_1111, "R10 strap low");
    // R6: refused write and status read in the same cycle
    wr_rd(5'h04, 32'h8, 5'h00, 32'h0000_1111, "R6 same-cycle read returns old flag");
    rd(5'h00, 32'h0010_1111, "R6 error flag set");
    rd(5'h00, 32'h0000_1111, "R6 error flag cleared");
    wr(5'h04, 32'h70);
    rd(5'h00, 32'h0010_1111, "R6 refused erase flags error");
    check(wr_count == 0 && er_count == 0, "R6 nothing started", 32'(wr_count + er_count), 0);
    wr(5'h04, 32'h2);
    rd(5'h00, 32'h0000_1110, "R2 unprotected status");
    t0 = trig_count;
    wr(5'h04, 32'h4);
    rd(5'h00, 32'h0000_1100, "R3 read idle low");
    wait_idle();
    rd(5'h10, 32'hDEAD_0005, "R3 read result, R6 protected write left word intact");
    check(trig_count == t0 + 1, "R13 one handshake per read", 32'(trig_count), 32'(t0 + 1));
    wr(5'h04, 32'h8);
    rd(5'h00, 32'h0000_0110, "R4 write idle low");
    wait_idle();
    check(mem[5] == 32'hA5A5_1234, "R4 flash word written", mem[5], 32'hA5A5_1234);
    wr(5'h04, 32'h4);
    wait_idle();
    rd(5'h10, 32'hA5A5_1234, "R4 readback through engine");
    wr(5'h04, 32'h70);
    rd(5'h00, 32'h0000_1010, "R5 erase idle low");
    wait_idle();
    check(last_sector == 3'd3 && er_count == 1, "R5 sector 3 erased", 32'(last_sector), 3);
    w0 = wr_count;
    wr(5'h04, 32'h4);
    wr(5'h04, 32'h8);
    wait_idle();
    check(wr_count == w0, "R7 write ignored while busy", 32'(wr_count), 32'(w0));
    rd(5'h00, 32'h0000_1110, "R7 no error flag");
    e0 = er_count;
    wr(5'h04, 32'h1C);
    rd(5'h00, 32'h0000_1100, "R8 read wins");
    wait_idle();
    check(wr_count == w0 && er_count == e0, "R8 others dropped", 32'(wr_count), 32'(w0));
    wr(5'h04, 32'h18);
    rd(5'h00, 32'h0000_0110, "R8 write over erase");
    wait_idle();
    check(wr_count == w0 + 1 && er_count == e0, "R8 erase dropped", 32'(er_count), 32'(e0));
    wr(5'h04, 32'h9);
    rd(5'h00, 32'h0000_0111, "R8 protect with write uses old latch");
    wait_idle();
    wr(5'h04, 32'h2);
    wr(5'h04, 32'h3);
    rd(5'h00, 32'h0000_1111, "R2 both strobes protect");
    rd(5'h1C, 32'h0, "R11 unmapped reads zero");
    rd(5'h04, 32'h0, "R11 command reads zero");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 all reads answered", 32'(exp_q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule